// File: doc/BRIEF.md
# Serial Flash Read Window

This block maps a 256 KB bus window onto an external serial flash. The lower 128 KB, offsets 0x00000 to 0x1FFFF, is the flash read window. A bus read of 4 or 8 bytes there becomes one complete serial read frame on the chip-select, serial clock, serial-out and serial-in pins. The request stays outstanding until every data byte has been shifted in. The assembled word then comes back on a response channel.

One register sits in the upper half, at offset 0x20000. It is a 32-bit divider that sets the serial clock rate. Every other access completes at once and causes no serial activity.

The bus side is a request channel with `req_valid`/`req_ready` and a response channel with `rsp_valid`/`rsp_ready`. Back-pressure works as follows:
- A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is low from acceptance until the response has been taken.
- A raised `rsp_valid` stays high with `rsp_data` unchanged until `rsp_ready` is seen high at a clock edge.

Top module: `spi_rd_window`

## Requirements
- R1: A read accepted with `req_addr[17]`=0 produces one frame, MSB first on `spi_mosi`. The frame carries command byte 0x03, then the 24-bit flash address formed as seven zero bits followed by `req_addr[16:0]`.
- R2: `req_size8`=0 selects 4 data bytes and `req_size8`=1 selects 8. A frame therefore has 64 or 96 rising serial clock edges between the fall and the rise of `spi_cs_n`.
- R3: From acceptance of a flash read until its response, `req_ready` is low. `rsp_valid` rises only after `spi_cs_n` has returned high.
- R4: Serial mode 0 is used. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_cs_n` falls while `spi_sck` is low. `spi_mosi` changes only on a falling `spi_sck` edge or a `spi_cs_n` transition. `spi_miso` is sampled on rising edges.
- R5: The divider register at offset 0x20000 (`req_addr`=18'h20000) resets to 0. A write loads `req_wdata`. A read returns the register in `rsp_data[31:0]`, with bits 63:32 zero.
- R6: Each half period of `spi_sck` lasts N bus clock cycles, where N is the divider value. A value of 0 acts as 1.
- R7: Byte k of `rsp_data` (bits 8k+7:8k) holds the flash byte at address base+k. For 4-byte reads, bits 63:32 are zero.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` does not change.
- R9: Writes to any address other than 0x20000, and reads of 0x20001 to 0x3FFFF, produce no `spi_cs_n` activity. Reads of that range return zero. Each such access still gets a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte offset inside the window |
| req_size8 | input | 1 | Flash read size: 0 = 4 bytes, 1 = 8 bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_data | output | 64 | Read data, little-endian |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with its default parameters: an 18-bit window offset, 8-byte maximum reads and a 32-bit divider. It programs divider values 0 to 4, which keeps every frame at a few hundred cycles. The frames still cover the 0-as-1 case, both read sizes, and addresses at the very top of the flash window. A behavioural flash model in the bench answers each frame, so that byte order, frame length and half-period length can all be compared against values computed from the requirements.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] CMD_READ = 8'h03;

  typedef enum logic [1:0] {
    TOP_IDLE = 2'd0,
    TOP_BUSY = 2'd1,
    TOP_RESP = 2'd2
  } top_state_t;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_t;
endpackage

// File: rtl/spi_rd_clkdiv.sv
module spi_rd_clkdiv #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // a divider of zero behaves like one
  assign limit = (divider == '0) ? DIV_W'(0) : divider - DIV_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
  import spi_rd_pkg::*;
#(
  parameter int FADDR_W  = 24,
  parameter int MAX_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [FADDR_W-1:0]     faddr,
  input  logic                   size8,
  input  logic                   tick,
  input  logic                   miso,
  output logic                   run,
  output logic                   cs_n,
  output logic                   sck,
  output logic                   mosi,
  output logic                   done,
  output logic [8*MAX_BYTES-1:0] shreg_in
);
  localparam int HDR_BITS = 8 + FADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 8*MAX_BYTES + 1);
  localparam int BITS_L   = HDR_BITS + 8*(MAX_BYTES/2);
  localparam int BITS_H   = HDR_BITS + 8*MAX_BYTES;

  eng_state_t          st;
  logic [HDR_BITS-1:0] out_sr;
  logic [CNT_W-1:0]    bitcnt;
  logic [CNT_W-1:0]    total;
  logic                big;

  assign total = big ? CNT_W'(BITS_H) : CNT_W'(BITS_L);
  assign run   = (st == ENG_SHIFT);
  assign mosi  = out_sr[HDR_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      out_sr   <= '0;
      bitcnt   <= '0;
      big      <= 1'b0;
      done     <= 1'b0;
      shreg_in <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ENG_IDLE: if (start) begin
          st     <= ENG_SHIFT;
          cs_n   <= 1'b0;
          sck    <= 1'b0;
          out_sr <= {CMD_READ, faddr};
          bitcnt <= '0;
          big    <= size8;
        end
        ENG_SHIFT: if (tick) begin
          if (!sck) begin
            sck      <= 1'b1;
            shreg_in <= {shreg_in[8*MAX_BYTES-2:0], miso};
            bitcnt   <= bitcnt + CNT_W'(1);
          end else begin
            sck <= 1'b0;
            if (bitcnt == total) begin
              cs_n <= 1'b1;
              st   <= ENG_IDLE;
              done <= 1'b1;
            end else begin
              out_sr <= {out_sr[HDR_BITS-2:0], 1'b0};
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  a_r4_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sck) || $fell(cs_n) || $rose(cs_n)));
  a_r6_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck));
endmodule

// File: rtl/spi_rd_window.sv
module spi_rd_window
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DIV_W     = 32,
  parameter int MAX_BYTES = 8,
  parameter int FADDR_W   = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_size8,
  input  logic [DIV_W-1:0]       req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [8*MAX_BYTES-1:0] rsp_data,
  output logic                   spi_cs_n,
  output logic                   spi_sck,
  output logic                   spi_mosi,
  input  logic                   spi_miso
);
  localparam int DW    = 8*MAX_BYTES;
  localparam int HALF  = MAX_BYTES/2;
  localparam int OFF_W = ADDR_W - 1;

  top_state_t     st;
  logic [DIV_W-1:0] divider;
  logic           size_q;
  logic           accept, is_flash, is_div;
  logic           tick, run, done;
  logic [DW-1:0]  shreg_in, packed_le;

  assign req_ready = (st == TOP_IDLE);
  assign rsp_valid = (st == TOP_RESP);
  assign accept    = req_valid && req_ready;
  assign is_flash  = !req_addr[ADDR_W-1];
  assign is_div    = req_addr[ADDR_W-1] && (req_addr[OFF_W-1:0] == '0);

  // first received byte lands in the lowest byte lane
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    if (k < HALF) begin : g_low
      assign packed_le[8*k +: 8] = size_q ? shreg_in[8*(MAX_BYTES-1-k) +: 8]
                                          : shreg_in[8*(HALF-1-k) +: 8];
    end else begin : g_high
      assign packed_le[8*k +: 8] = size_q ? shreg_in[8*(MAX_BYTES-1-k) +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TOP_IDLE;
      divider  <= '0;
      size_q   <= 1'b0;
      rsp_data <= '0;
    end else begin
      case (st)
        TOP_IDLE: if (accept) begin
          size_q <= req_size8;
          if (!req_write && is_flash) begin
            st <= TOP_BUSY;
          end else begin
            st       <= TOP_RESP;
            rsp_data <= (!req_write && is_div) ? DW'(divider) : '0;
            if (req_write && is_div) divider <= req_wdata;
          end
        end
        TOP_BUSY: if (done) begin
          st       <= TOP_RESP;
          rsp_data <= packed_le;
        end
        TOP_RESP: if (rsp_ready) st <= TOP_IDLE;
        default: st <= TOP_IDLE;
      endcase
    end
  end

  spi_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .divider(divider), .tick(tick)
  );

  spi_rd_engine #(.FADDR_W(FADDR_W), .MAX_BYTES(MAX_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(accept && !req_write && is_flash),
    .faddr(FADDR_W'(req_addr[OFF_W-1:0])),
    .size8(req_size8), .tick(tick), .miso(spi_miso),
    .run(run), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .done(done), .shreg_in(shreg_in)
  );

  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);
  a_r3_resp_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> spi_cs_n);
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/spi_rd_window_test.sv
module spi_rd_window_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {divider[7:0], size8, offset[16:0]}
  localparam logic [25:0] VEC [NV] = '{
    {8'd1, 1'b0, 17'h00000},
    {8'd2, 1'b1, 17'h00100},
    {8'd3, 1'b0, 17'h1FFFC},
    {8'd1, 1'b1, 17'h1FFF8},
    {8'd4, 1'b1, 17'h0ABC0},
    {8'd0, 1'b0, 17'h12344}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_size8 = 0, rsp_ready = 0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 0;
  logic [63:0] rsp_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  int mon_bits = 0, cs_falls = 0;
  logic [31:0] mon_hdr = '0;
  time t_r0 = 0, t_r1 = 0;

  spi_rd_window uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[16], 7'h3C};
  endfunction

  // flash model
  always @(negedge spi_cs_n) begin
    mon_bits = 0; cs_falls++;
    checks++;
    if (spi_sck !== 1'b0) begin
      failures++; $display("FAIL R4 cs fall with sck=%b expected 0", spi_sck);
    end
  end
  always @(posedge spi_sck) begin
    if (mon_bits < 32) mon_hdr = {mon_hdr[30:0], spi_mosi};
    if (mon_bits == 0) t_r0 = $time;
    if (mon_bits == 1) t_r1 = $time;
    mon_bits++;
  end
  always @(negedge spi_sck) begin
    if (mon_bits >= 32) begin
      automatic int idx = mon_bits - 32;
      automatic logic [7:0] b = fbyte(mon_hdr[23:0] + 24'(idx/8));
      spi_miso = b[7 - (idx % 8)];
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [17:0] a, input logic s8,
                        input logic [31:0] wd, output logic [63:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size8 = s8; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    data = rsp_data;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, exp, held;
    int falls0;
    repeat (3) @(negedge clk);
    // reset state
    check("R4 reset cs_n", 64'(spi_cs_n), 64'd1);
    check("R4 reset sck", 64'(spi_sck), 64'd0);
    check("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R3 idle req_ready", 64'(req_ready), 64'd1);
    access(1'b0, 18'h20000, 1'b0, 32'h0, d);
    check("R5 divider reset value", d, 64'd0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [7:0]  dv  = VEC[i][25:18];
      automatic logic        s8  = VEC[i][17];
      automatic logic [16:0] off = VEC[i][16:0];
      automatic int eff = (dv == 0) ? 1 : int'(dv);
      automatic int nb  = s8 ? 8 : 4;
      access(1'b1, 18'h20000, 1'b0, 32'(dv), d);
      access(1'b0, 18'h20000, 1'b0, 32'h0, d);
      check("R5 divider readback", d, 64'(dv));
      exp = '0;
      for (int k = 0; k < nb; k++) exp[8*k +: 8] = fbyte(24'(off) + 24'(k));
      // accept and check busy mid-frame
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = {1'b0, off}; req_size8 = s8;
      @(negedge clk);
      req_valid = 0;
      repeat (4) @(negedge clk);
      check("R3 req_ready low during frame", 64'(req_ready), 64'd0);
      while (!rsp_valid) @(negedge clk);
      check("R3 cs_n high at response", 64'(spi_cs_n), 64'd1);
      check("R7 read data", rsp_data, exp);
      check("R1 command and address", 64'(mon_hdr), {32'h0, 8'h03, 7'h0, off});
      check("R2 rising edges per frame", 64'(mon_bits), 64'(32 + 8*nb));
      check("R6 sck period", 64'((t_r1 - t_r0) / CLK_PERIOD), 64'(2*eff));
      if (i == 1) begin
        held = rsp_data;
        repeat (5) @(negedge clk);
        check("R8 rsp_valid held", 64'(rsp_valid), 64'd1);
        check("R8 rsp_data stable", rsp_data, held);
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
      check("R8 rsp_valid drops after take", 64'(rsp_valid), 64'd0);
    end

    // accesses that must not touch the flash
    falls0 = cs_falls;
    access(1'b1, 18'h00040, 1'b0, 32'hDEADBEEF, d);
    access(1'b0, 18'h20008, 1'b1, 32'h0, d);
    check("R9 other read returns zero", d, 64'd0);
    access(1'b0, 18'h3FFFC, 1'b0, 32'h0, d);
    check("R9 top read returns zero", d, 64'd0);
    access(1'b1, 18'h20010, 1'b0, 32'h55, d);
    access(1'b0, 18'h20000, 1'b0, 32'h0, d);
    check("R9 write elsewhere leaves divider", d, 64'd0);
    check("R9 no cs activity", 64'(cs_falls - falls0), 64'd0);
    check("R3 ready after stray accesses", 64'(req_ready), 64'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule